// File: doc/BRIEF.md
# Mantissa Rounding Unit

This block is the rounding step of a floating-point datapath. It takes an unpacked, normalized mantissa whose two lowest bits are the guard and round bits, together with a separate sticky bit, the sign of the value and a 2-bit rounding-mode code. It first discards the guard and round bits by shifting the mantissa right two places. It then decides from the mode, the sign and the discarded bits whether the kept mantissa must be incremented, and adds one with a carry across the full width.

The result comes out one bit wider than the kept mantissa. The extra top bit catches the carry when an all-ones mantissa rounds up to 2.0. That value is left unnormalized on purpose: exponent adjustment, renormalization, overflow detection and packing belong to the next stage.

The unit reports three things besides the mantissa:
- a rounded-up indication;
- an inexact flag and a fraction-inexact flag, which always rise together;
- a fraction-rounded flag.

It is registered with a valid-in/valid-out handshake and one cycle of latency.

Top module: `mant_round_unit`

## Requirements
- R1: A synchronous active-high reset clears `valid_o`. Outside reset, `valid_o` equals the `valid_i` of the previous clock cycle, so a result appears one cycle after its operands.
- R2: The kept mantissa is `mant_i[MANT_W-1:2]`. The output is `mant_o = {1'b0, mant_i[MANT_W-1:2]} + inc`, which is `MANT_W-1` bits wide, where `inc` is the increment decision.
- R3: When `mant_i[1]` (guard), `mant_i[0]` (round) and `sticky_i` are all 0, the result is exact. The kept mantissa passes through unchanged and every flag and `rounded_up_o` is 0.
- R4: When any of guard, round or sticky is 1, both `inexact_o` and `frac_inexact_o` are 1, whatever the mode.
- R5: In mode `2'b00` (nearest, ties to even), the unit increments only when guard is 1 and at least one of the following is 1: round, sticky, or the kept LSB `mant_i[2]`.
- R6: In mode `2'b01` (toward zero), the unit never increments.
- R7: In mode `2'b10` (toward plus infinity), the unit increments only when the result is inexact and `sign_i` is 0. In mode `2'b11` (toward minus infinity), it increments only when the result is inexact and `sign_i` is 1.
- R8: `rounded_up_o` and `frac_round_o` are both 1 when an increment happened and both 0 otherwise.
- R9: An increment of an all-ones kept mantissa yields `mant_o` with only its top bit set (the value 2.0), with no correction applied.
- R10: A clock cycle with `valid_i` low leaves `mant_o` and all four flag outputs unchanged, and drives `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operands are valid this cycle |
| mant_i | input | MANT_W | Normalized mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| sign_i | input | 1 | Sign of the value (1 means negative) |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| valid_o | output | 1 | Result valid |
| mant_o | output | MANT_W-1 | Rounded mantissa, including the carry bit |
| rounded_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Discarded bits were nonzero |
| frac_inexact_o | output | 1 | Fraction-inexact status, raised with `inexact_o` |
| frac_round_o | output | 1 | Fraction-rounded status, raised on increment |

## Verification
The bench targets the exact halfway case in nearest mode. Here an odd kept LSB must round up and an even one must not; a design without tie-to-even would bias every tie the same way. It also targets sticky-only inexact inputs, where a design that ignores sticky would report the result as exact and skip directed-mode increments. Finally, it covers the sign dependence of the two directed modes, where a swapped sign test rounds the wrong way, and the all-ones carry into the extra bit, which a truncated adder would wrap to zero.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

    typedef enum logic [1:0] {
        RMODE_NEAREST = 2'b00,
        RMODE_ZERO    = 2'b01,
        RMODE_PLUS    = 2'b10,
        RMODE_MINUS   = 2'b11
    } rmode_e;

endpackage

// File: rtl/mant_round_decide.sv
module mant_round_decide
    import mant_round_pkg::*;
(
    input  logic [1:0] gr_i,
    input  logic       sticky_i,
    input  logic       lsb_i,
    input  logic       sign_i,
    input  rmode_e     mode_i,
    output logic       inexact_o,
    output logic       inc_o
);

    logic lost_d;
    logic inc_d;

    always_comb begin
        lost_d = gr_i[1] | gr_i[0] | sticky_i;
        inc_d  = 1'b0;
        if (lost_d) begin
            unique case (mode_i)
                RMODE_NEAREST: inc_d = gr_i[1] & (gr_i[0] | sticky_i | lsb_i);
                RMODE_ZERO:    inc_d = 1'b0;
                RMODE_PLUS:    inc_d = ~sign_i;
                RMODE_MINUS:   inc_d = sign_i;
                default:       inc_d = 1'b0;
            endcase
        end
    end

    assign inexact_o = lost_d;
    assign inc_o     = inc_d;

    always_comb begin
        if (mode_i == RMODE_ZERO)
            assert_rz_never_inc_R6: assert (!inc_o);
        if (!gr_i[1] && !gr_i[0] && !sticky_i)
            assert_exact_no_inc_R3: assert (!inc_o);
    end

endmodule

// File: rtl/mant_round_incr.sv
module mant_round_incr #(
    parameter int W     = 24,
    parameter int SEG_W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic         inc_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    localparam int NSEG = (W + SEG_W - 1) / SEG_W;

    logic [NSEG:0]   seg_c;
    logic [NSEG-1:0] seg_all;

    assign seg_c[0] = inc_i;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int LO = k * SEG_W;
        localparam int HI = ((LO + SEG_W) > W) ? W : (LO + SEG_W);
        localparam int SW = HI - LO;

        logic [SW-1:0] a_s;
        logic [SW-1:0] c_s;

        assign a_s        = a_i[HI-1:LO];
        assign seg_all[k] = &a_s;

        for (genvar j = 0; j < SW; j++) begin : g_bit
            if (j == 0) begin : g_first
                assign c_s[j] = seg_c[k];
            end else begin : g_rest
                assign c_s[j] = seg_c[k] & (&a_s[j-1:0]);
            end
        end

        assign sum_o[HI-1:LO] = a_s ^ c_s;
        assign seg_c[k+1]     = seg_c[k] & seg_all[k];
    end

    assign carry_o = seg_c[NSEG];

    always_comb begin
        if (carry_o)
            assert_carry_wraps_R9: assert (sum_o == '0);
    end

endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
    import mant_round_pkg::*;
#(
    parameter int MANT_W = 26,
    parameter int SEG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic              sign_i,
    input  logic [1:0]        mode_i,
    output logic              valid_o,
    output logic [MANT_W-2:0] mant_o,
    output logic              rounded_up_o,
    output logic              inexact_o,
    output logic              frac_inexact_o,
    output logic              frac_round_o
);

    localparam int KEEP_W = MANT_W - 2;
    localparam int OUT_W  = KEEP_W + 1;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] mant;
        logic             up;
        logic             inx;
        logic             fr;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [KEEP_W-1:0] kept;
    logic [KEEP_W-1:0] kept_sum;
    logic              kept_carry;
    logic              lost;
    logic              inc;

    assign kept = mant_i[MANT_W-1:2];

    mant_round_decide u_decide (
        .gr_i      (mant_i[1:0]),
        .sticky_i  (sticky_i),
        .lsb_i     (mant_i[2]),
        .sign_i    (sign_i),
        .mode_i    (rmode_e'(mode_i)),
        .inexact_o (lost),
        .inc_o     (inc)
    );

    mant_round_incr #(
        .W     (KEEP_W),
        .SEG_W (SEG_W)
    ) u_incr (
        .a_i     (kept),
        .inc_i   (inc),
        .sum_o   (kept_sum),
        .carry_o (kept_carry)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = valid_i;
        if (valid_i) begin
            stage_d.mant = {kept_carry, kept_sum};
            stage_d.up   = inc;
            stage_d.inx  = lost;
            stage_d.fr   = inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign valid_o        = stage_q.valid;
    assign mant_o         = stage_q.mant;
    assign rounded_up_o   = stage_q.up;
    assign inexact_o      = stage_q.inx;
    assign frac_inexact_o = stage_q.inx;
    assign frac_round_o   = stage_q.fr;

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);

    assert_exact_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mant_i[1:0] == 2'b00 && !sticky_i) |=>
            (!inexact_o && !rounded_up_o && !frac_round_o));

    assert_inexact_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (mant_i[1:0] != 2'b00 || sticky_i)) |=> (inexact_o && frac_inexact_o));

    assert_rz_no_round_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i == 2'b01) |=> !rounded_up_o);

    assert_round_implies_inexact_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_o && rounded_up_o) |-> (frac_round_o && inexact_o));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(mant_o) && !valid_o));

endmodule

// File: tb/sim_mant_round_unit.sv
module sim_mant_round_unit;

    localparam int MW = 8;
    localparam int OW = MW - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          valid_i;
    logic [MW-1:0] mant_i;
    logic          sticky_i;
    logic          sign_i;
    logic [1:0]    mode_i;
    logic          valid_o;
    logic [OW-1:0] mant_o;
    logic          rounded_up_o;
    logic          inexact_o;
    logic          frac_inexact_o;
    logic          frac_round_o;

    int  n_chk  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    mant_round_unit #(.MANT_W(MW), .SEG_W(3)) u0 (
        .clk            (clk),
        .rst            (rst),
        .valid_i        (valid_i),
        .mant_i         (mant_i),
        .sticky_i       (sticky_i),
        .sign_i         (sign_i),
        .mode_i         (mode_i),
        .valid_o        (valid_o),
        .mant_o         (mant_o),
        .rounded_up_o   (rounded_up_o),
        .inexact_o      (inexact_o),
        .frac_inexact_o (frac_inexact_o),
        .frac_round_o   (frac_round_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        rst = 1'b1; valid_i = 1'b0; mant_i = '0; sticky_i = 1'b0; sign_i = 1'b0; mode_i = 2'b00;
        repeat (3) @(negedge clk);
        chk("R1 valid_o in reset", int'(valid_o), 0);
        rst = 1'b0;

        for (int md = 0; md < 4; md++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int m = 0; m < (1 << MW); m++) begin
                        int    kept, g, r, lsb, lost, inc, emant;
                        string tag;
                        kept = m >> 2;
                        g    = (m >> 1) & 1;
                        r    = m & 1;
                        lsb  = kept & 1;
                        lost = (g | r | st) != 0 ? 1 : 0;
                        inc  = 0;
                        if (lost != 0) begin
                            case (md)
                                0: inc = (g != 0 && (r != 0 || st != 0 || lsb != 0)) ? 1 : 0;
                                1: inc = 0;
                                2: inc = (sg == 0) ? 1 : 0;
                                default: inc = (sg == 1) ? 1 : 0;
                            endcase
                        end
                        emant = kept + inc;
                        if (lost == 0)              tag = "R3 exact";
                        else if (md == 0)           tag = "R5 nearest";
                        else if (md == 1)           tag = "R6 toward zero";
                        else                        tag = "R7 directed";
                        valid_i  = 1'b1;
                        mant_i   = MW'(m);
                        sticky_i = st[0];
                        sign_i   = sg[0];
                        mode_i   = md[1:0];
                        @(negedge clk);
                        chk({tag, " R1 valid"}, int'(valid_o), 1);
                        if (kept == (1 << (MW - 2)) - 1 && inc == 1)
                            chk({tag, " R9 carry to 2.0 mant"}, int'(mant_o), emant);
                        else
                            chk({tag, " R2 mant"}, int'(mant_o), emant);
                        chk({tag, " R4 inexact"}, int'(inexact_o), lost);
                        chk({tag, " R4 frac_inexact"}, int'(frac_inexact_o), lost);
                        chk({tag, " R8 rounded_up"}, int'(rounded_up_o), inc);
                        chk({tag, " R8 frac_round"}, int'(frac_round_o), inc);
                    end
                end
            end
        end

        // Directed tie cases in nearest mode, R5
        valid_i = 1'b1; mode_i = 2'b00; sticky_i = 1'b0; sign_i = 1'b0;
        mant_i = 8'b0000_0110;  // kept odd, guard only: round up to 2
        @(negedge clk);
        chk("R5 tie odd mant", int'(mant_o), 2);
        mant_i = 8'b0000_1010;  // kept even (2), guard only: stay 2
        @(negedge clk);
        chk("R5 tie even mant", int'(mant_o), 2);

        // R9 explicit: all-ones kept with guard set
        mant_i = 8'hFF;
        @(negedge clk);
        chk("R9 carry 2.0", int'(mant_o), 1 << (MW - 2));

        // R10: idle cycles leave outputs unchanged
        valid_i = 1'b0; mant_i = 8'h03; sticky_i = 1'b1; mode_i = 2'b10;
        repeat (2) begin
            @(negedge clk);
            chk("R10 valid_o idle", int'(valid_o), 0);
            chk("R10 mant held", int'(mant_o), 1 << (MW - 2));
            chk("R10 rounded_up held", int'(rounded_up_o), 1);
            chk("R10 inexact held", int'(inexact_o), 1);
        end

        // R1: reset clears valid_o after activity
        valid_i = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears valid", int'(valid_o), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule